// File: doc/BRIEF.md
# Region-Selecting Auto-Step Address Counter

This block holds the RAM address used by a character display controller. An address-set operation does two things in one clock. It loads a 7-bit address, and it chooses which memory the address points into: the display text store, the character-generator store or the segment store. The controller then reads or writes that memory. After every such read or write, the counter moves by one so that the next access reaches the next location.

The direction of the step comes from a single bit in a small entry-mode register inside the block. A one makes the counter count up and a zero makes it count down. The count wraps around at both ends of the 7-bit range. The block drives the current address and the current region code to the memory muxes. It does not decode instructions beyond the address and region fields, and it contains no memories and no bus timing.

Top module: `addr_ctr_top`

## Requirements
- R1: After reset, the address is 0, the region code is 0 (display) and the step direction is up.
- R2: When `ld_en` is high with a valid region code, the clock edge loads `ld_addr` into the address and `ld_region` into the region. Bit 6 is the MSB, so display address 0x4A appears as 1001010.
- R3: The region codes are 0 for display data, 1 for character generator and 2 for segment memory. Code 3 is reserved. A load that carries code 3 is treated as if no load were present, and the region output never shows 3.
- R4: A cycle with `rd_en` or `wr_en` high and no valid load changes the address by exactly one at the next edge, in the current direction. A cycle with both strobes high gives a single step.
- R5: `mode_we` stores `mode_inc` as the direction (1 = up, 0 = down). A strobe in the same cycle as the mode write still uses the previous direction.
- R6: Stepping wraps modulo 128: up from 127 gives 0, and down from 0 gives 127.
- R7: When a valid load and a strobe occur in the same cycle, the load wins and no step is applied.
- R8: Steps never change the region. With no load and no strobe, the address and the region hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Write strobe for the entry-mode direction bit |
| mode_inc | input | 1 | Direction value to store (1 = up, 0 = down) |
| ld_en | input | 1 | Address-set strobe |
| ld_addr | input | 7 | Address to load |
| ld_region | input | 2 | Target region code for the load |
| rd_en | input | 1 | Memory read access strobe |
| wr_en | input | 1 | Memory write access strobe |
| addr | output | 7 | Current address |
| region | output | 2 | Current region code |

## Verification
Every result of this block comes out of one register stage. A load, a step or a mode write made in the cycle before a rising edge shows at the ports right after that edge.

The bench drives each stimulus for one cycle, just after an edge. It samples `addr` and `region` one time unit after the next rising edge, clear of the active edge. A change in direction cannot be seen directly at the ports, so the bench checks it through the next step. That step is driven in the cycle after the mode write, except in the case that tests a strobe in the same cycle as the mode write.

// File: rtl/addr_ctr_pkg.sv
package addr_ctr_pkg;
   typedef enum logic [1:0] {
      RGN_DISP = 2'd0,
      RGN_CGEN = 2'd1,
      RGN_SEG  = 2'd2,
      RGN_RSVD = 2'd3
   } region_e;
endpackage

// File: rtl/addr_ctr_mode.sv
module addr_ctr_mode #(
   parameter bit RST_INC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic inc_in,
   output logic inc_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  inc_q <= RST_INC;
      else if (we) inc_q <= inc_in;
   end

   assert_mode_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> inc_q == $past(inc_in));
   assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(inc_q));
endmodule

// File: rtl/addr_ctr_region.sv
module addr_ctr_region
   import addr_ctr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    ld,
   input  region_e ld_rgn,
   output region_e rgn_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  rgn_q <= RGN_DISP;
      else if (ld) rgn_q <= ld_rgn;
   end

   assert_region_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> rgn_q != RGN_RSVD);
   assert_region_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(rgn_q));
endmodule

// File: rtl/addr_ctr_step.sv
module addr_ctr_step #(
   parameter int unsigned ADDR_W     = 7,
   parameter bit          USE_ADDER  = 1'b0,
   parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic              step,
   input  logic              inc,
   output logic [ADDR_W-1:0] q
);
   localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

   if (ADDR_W < 2) begin : g_bad_width
      $error("addr_ctr_step: ADDR_W must be at least 2");
   end

   logic [ADDR_W-1:0] nxt;

   if (USE_ADDER) begin : g_adder
      assign nxt = inc ? q + ONE : q - ONE;
   end else begin : g_toggle
      logic [ADDR_W-1:0] tog;
      assign tog[0] = 1'b1;
      for (genvar i = 1; i < ADDR_W; i++) begin : g_bit
         assign tog[i] = tog[i-1] & (inc ? q[i-1] : ~q[i-1]);
      end
      assign nxt = q ^ tog;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= RST_ADDR;
      else if (ld)   q <= ld_val;
      else if (step) q <= nxt;
   end

   assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> q == $past(ld_val));
   assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && step && inc) |=> q == $past(q) + ONE);
   assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && step && !inc) |=> q == $past(q) - ONE);
   assert_wrap_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && step && inc && q == LAST) |=> q == '0);
   assert_wrap_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && step && !inc && q == '0) |=> q == LAST);
   assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !step) |=> $stable(q));
endmodule

// File: rtl/addr_ctr_top.sv
module addr_ctr_top
   import addr_ctr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 7,
   parameter bit          USE_ADDER = 1'b0,
   parameter bit          RST_INC   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic              mode_inc,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [1:0]        ld_region,
   input  logic              rd_en,
   input  logic              wr_en,
   output logic [ADDR_W-1:0] addr,
   output logic [1:0]        region
);
   localparam logic [ADDR_W-1:0] RST_ADDR = '0;

   region_e ld_rgn, rgn_q;
   logic    ld_ok, access, inc_q;

   assign ld_rgn = region_e'(ld_region);
   assign ld_ok  = ld_en && (ld_rgn != RGN_RSVD);
   assign access = rd_en | wr_en;
   assign region = rgn_q;

   addr_ctr_mode #(.RST_INC(RST_INC)) u_mode (
      .clk(clk), .rst_n(rst_n), .we(mode_we), .inc_in(mode_inc), .inc_q(inc_q));

   addr_ctr_region u_region (
      .clk(clk), .rst_n(rst_n), .ld(ld_ok), .ld_rgn(ld_rgn), .rgn_q(rgn_q));

   addr_ctr_step #(.ADDR_W(ADDR_W), .USE_ADDER(USE_ADDER), .RST_ADDR(RST_ADDR)) u_step (
      .clk(clk), .rst_n(rst_n), .ld(ld_ok), .ld_val(ld_addr),
      .step(access), .inc(inc_q), .q(addr));

   assert_rsvd_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_region == 2'd3 && !rd_en && !wr_en) |=> $stable(addr) && $stable(region));
   assert_load_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_region != 2'd3) |=> region == $past(ld_region));
endmodule

// File: tb/addr_ctr_top_tb_top.sv
module addr_ctr_top_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_we = 0, mode_inc = 0, ld_en = 0, rd_en = 0, wr_en = 0;
   logic [6:0] ld_addr = '0;
   logic [1:0] ld_region = '0;
   logic [6:0] addr;
   logic [1:0] region;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   addr_ctr_top dut_i (.*);

   initial begin : watchdog
      #40000;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic check(input string req, input logic [6:0] ea, input logic [1:0] er);
      checks++;
      if (addr !== ea || region !== er) begin
         errors++;
         $display("FAIL %s: actual addr=%h region=%0d expected addr=%h region=%0d",
                  req, addr, region, ea, er);
      end
   endtask

   // one cycle of stimulus, sampled 1 time unit after the capturing edge
   task automatic cyc(input logic mw, input logic mi, input logic ld, input logic [6:0] a,
                      input logic [1:0] r, input logic rd, input logic wr);
      mode_we = mw; mode_inc = mi; ld_en = ld; ld_addr = a; ld_region = r;
      rd_en = rd; wr_en = wr;
      @(posedge clk); #1;
      mode_we = 0; ld_en = 0; rd_en = 0; wr_en = 0;
   endtask

   task automatic t_reset();
      rst_n = 0; repeat (2) @(posedge clk); #1; rst_n = 1;
      check("R1 reset", 7'h00, 2'd0);
      cyc(0,0,0,0,0,1,0);
      check("R1 reset direction up", 7'h01, 2'd0);
   endtask

   task automatic t_load();
      cyc(0,0,1,7'h4A,2'd0,0,0);
      check("R2 display 0x4A", 7'b1001010, 2'd0);
      cyc(0,0,1,7'h15,2'd1,0,0);
      check("R2 R3 chargen load", 7'h15, 2'd1);
      cyc(0,0,1,7'h63,2'd2,0,0);
      check("R2 R3 segment load", 7'h63, 2'd2);
   endtask

   task automatic t_reserved();
      cyc(0,0,1,7'h11,2'd3,0,0);
      check("R3 reserved load ignored", 7'h63, 2'd2);
      cyc(0,0,1,7'h11,2'd3,0,1);
      check("R3 reserved load with write steps", 7'h64, 2'd2);
   endtask

   task automatic t_steps();
      cyc(1,1,1,7'h20,2'd1,0,0);
      cyc(0,0,0,0,0,1,0);
      check("R4 read step up", 7'h21, 2'd1);
      cyc(0,0,0,0,0,0,1);
      check("R4 write step up", 7'h22, 2'd1);
      cyc(0,0,0,0,0,1,1);
      check("R4 read+write single step", 7'h23, 2'd1);
      cyc(0,0,0,0,0,0,0);
      check("R8 idle hold", 7'h23, 2'd1);
   endtask

   task automatic t_direction();
      cyc(1,0,0,0,0,0,0);
      check("R5 mode write alone no step", 7'h23, 2'd1);
      cyc(0,0,0,0,0,0,1);
      check("R5 step down", 7'h22, 2'd1);
      cyc(1,1,0,0,0,1,0);
      check("R5 same-cycle uses old direction", 7'h21, 2'd1);
      cyc(0,0,0,0,0,1,0);
      check("R5 new direction up", 7'h22, 2'd1);
   endtask

   task automatic t_wrap();
      cyc(0,0,1,7'h7F,2'd0,0,0);
      cyc(0,0,0,0,0,0,1);
      check("R6 wrap up", 7'h00, 2'd0);
      cyc(1,0,0,0,0,0,0);
      cyc(0,0,0,0,0,1,0);
      check("R6 wrap down", 7'h7F, 2'd0);
      cyc(0,0,0,0,0,1,0);
      check("R6 R8 down after wrap, region kept", 7'h7E, 2'd0);
   endtask

   task automatic t_collision();
      cyc(0,0,1,7'h30,2'd2,1,1);
      check("R7 load wins over access", 7'h30, 2'd2);
      cyc(1,1,1,7'h05,2'd1,0,1);
      check("R7 load wins with mode write", 7'h05, 2'd1);
   endtask

   initial begin
      t_reset();
      t_load();
      t_reserved();
      t_steps();
      t_direction();
      t_wrap();
      t_collision();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule